// File: doc/BRIEF.md
# Dual-Speed Memory Cycle Scheduler

This block sits between a CPU bus and a memory system that has two timing domains. For each CPU request it decides whether the access runs as a short (fast) cycle or a long (slow) cycle. It holds the CPU with a ready/wait signal until the chosen number of master clocks has elapsed. It also schedules dynamic RAM refresh for the fast memory region. Everything runs from one master clock, and the two cycle lengths are counts of that clock.

The speed is chosen for each access. With the speed-mode input set to fast, the lower half of the bank space, the ROM and a small group of fast-interface I/O registers get the short cycle. Every other bank, including the two shared video/I/O banks, always gets the long cycle. With the mode set to slow, everything uses the long cycle.

Refresh behaves differently in the two modes. In fast mode a refresh steals a whole fast-length slot and stalls the CPU. A pending refresh never holds off a fast ROM access, and it waits for the next slot without such a request. In slow mode the refresh strobe is issued in the spare half of the bus cycle and costs the CPU nothing.

Top module: `speed_cycle_ctrl`

## Requirements
- R1: While reset is held and on the first clock after it, `ready` is 1, `cyc_fast` is 0 and `refresh` is 0.
- R2: A request is accepted in a cycle where `req` and `ready` are both 1. After the accepting cycle, `ready` is 0 for LEN-1 cycles and then returns to 1, so an access occupies LEN master clocks. The requester keeps `req` and its attributes steady until it is accepted.
- R3: With `fast_mode`=1, an access whose bank has its most significant bit clear (banks 0x00–0x7F), or with `rom_sel`=1, or with `fio_sel`=1, is fast: LEN=FAST_LEN, and `cyc_fast` reads 1 from the cycle after acceptance.
- R4: An access to any bank with the most significant bit set (0x80–0xFF, including 0xE0 and 0xE1), with `rom_sel`=0 and `fio_sel`=0, is slow: LEN=SLOW_LEN and `cyc_fast`=0, whatever the mode.
- R5: With `fast_mode`=0, every access is slow, whatever the bank and flags.
- R6: A free-running timer makes a refresh due once every REF_INTERVAL clocks. On an idle bus, `refresh` pulses for exactly one clock, once per interval.
- R7: In fast mode a refresh is a stolen cycle: `ready` is 0 in the strobe cycle and for FAST_LEN-1 cycles after it, FAST_LEN clocks in total.
- R8: A non-ROM request that meets a stolen refresh is held with `ready` low. It is accepted on the first clock after the stolen cycle ends.
- R9: A fast ROM request arriving while a refresh is due is accepted at once without a strobe. The refresh is then stolen in the first idle cycle after that access.
- R10: In slow mode a refresh strobe never lowers `ready`. An idle bus keeps `ready`=1 while still receiving one strobe per interval.
- R11: A change of `fast_mode` during an access changes neither that access's length nor its `cyc_fast` value. The change applies from the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request, held until accepted |
| bank | input | BANK_W | Bank number of the access |
| rom_sel | input | 1 | Access targets ROM |
| fio_sel | input | 1 | Access targets a fast-interface I/O register |
| fast_mode | input | 1 | Global speed mode: 1 fast, 0 slow |
| ready | output | 1 | 1 when a request may be accepted; 0 holds the CPU |
| cyc_fast | output | 1 | Type of the current or last accepted access (1 fast) |
| refresh | output | 1 | One-clock refresh strobe |

## Verification
The assertions assume the requester obeys the handshake: `req` and its attributes stay steady until a cycle where `ready` is high, and they may only change after that acceptance. They also assume REFRESH_INTERVAL is well above FAST_LEN, so at most one refresh is ever pending. The stimulus keeps to both. Every request is driven on the falling clock edge and held until ready is seen high, and is then dropped on the next falling edge. The bench instance uses a refresh interval of 64 against a fast length of 4. To hit the refresh corner cases exactly, the bench waits for an observed strobe and counts one interval forward before it launches a request.

// File: rtl/spd_pkg.sv
package spd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACCESS,
    ST_REFRESH
  } seq_state_t;

  // Speed class of one access under the effective mode.
  function automatic logic fast_class(input logic mode_fast,
                                      input logic low_half,
                                      input logic rom,
                                      input logic fio);
    return mode_fast && (low_half || rom || fio);
  endfunction

  // Counter preload: the accepting clock is the first clock of a slot.
  function automatic int unsigned slot_preload(input int unsigned len);
    return len - 2;
  endfunction

endpackage

// File: rtl/speed_class.sv
module speed_class #(
  parameter int BANK_W = 8
) (
  input  logic              eff_mode,
  input  logic [BANK_W-1:0] bank,
  input  logic              rom_sel,
  input  logic              fio_sel,
  output logic              acc_fast
);
  localparam logic [BANK_W-1:0] HALF = BANK_W'(1) << (BANK_W - 1);

  logic low_half;
  assign low_half = (bank < HALF);
  assign acc_fast = spd_pkg::fast_class(eff_mode, low_half, rom_sel, fio_sel);
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int REF_INTERVAL = 1280
) (
  input  logic clk,
  input  logic rst_n,
  input  logic serve,
  output logic due
);
  localparam int CW = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(REF_INTERVAL - 1);

  logic [CW-1:0] cnt_q;
  logic          due_q;
  logic          tick;

  assign tick = (cnt_q == LAST);
  assign due  = due_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      due_q <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      due_q <= tick | (due_q & ~serve);
    end
  end

  // R6
  tick_sets_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> due_q);
endmodule

// File: rtl/cycle_seq.sv
module cycle_seq #(
  parameter int FAST_LEN = 10,
  parameter int SLOW_LEN = 28
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic rom_sel,
  input  logic fast_mode,
  input  logic acc_fast,
  input  logic due,
  output logic eff_mode,
  output logic serve,
  output logic ready,
  output logic cyc_fast,
  output logic refresh
);
  import spd_pkg::*;

  localparam int MAXL = (SLOW_LEN > FAST_LEN) ? SLOW_LEN : FAST_LEN;
  localparam int CNT_W = $clog2(MAXL + 1);
  localparam logic [CNT_W-1:0] FAST_LOAD = CNT_W'(slot_preload(FAST_LEN));
  localparam logic [CNT_W-1:0] SLOW_LOAD = CNT_W'(slot_preload(SLOW_LEN));

  seq_state_t     state_q;
  logic [CNT_W-1:0] cnt_q;
  logic           mode_q;
  logic           type_q;

  logic idle, rom_first, steal_now, hidden_now, accept;

  assign idle       = (state_q == ST_IDLE);
  // The mode is sampled live only between accesses.
  assign eff_mode   = idle ? fast_mode : mode_q;
  assign rom_first  = req && rom_sel && acc_fast;
  assign steal_now  = idle && due && eff_mode && !rom_first;
  assign hidden_now = due && !eff_mode && (state_q != ST_REFRESH);
  assign ready      = idle && !steal_now;
  assign accept     = req && ready;
  assign serve      = steal_now || hidden_now;
  assign refresh    = serve;
  assign cyc_fast   = type_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
      type_q  <= 1'b0;
    end else begin
      mode_q <= eff_mode;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_ACCESS;
            cnt_q   <= acc_fast ? FAST_LOAD : SLOW_LOAD;
            type_q  <= acc_fast;
          end else if (steal_now) begin
            state_q <= ST_REFRESH;
            cnt_q   <= FAST_LOAD;
          end
        end
        ST_ACCESS, ST_REFRESH: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  accept_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready) |=> !ready);

  // R6
  refresh_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> !refresh);

  // R7
  steal_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && eff_mode) |-> !ready);

  // R9
  rom_nodelay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && req && rom_sel && acc_fast) |-> (ready && !refresh));

  // R10
  slow_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && !eff_mode && idle) |-> ready);

  // R11
  type_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(!ready)) |-> $stable(cyc_fast));
endmodule

// File: rtl/speed_cycle_ctrl.sv
module speed_cycle_ctrl #(
  parameter int BANK_W       = 8,
  parameter int FAST_LEN     = 10,
  parameter int SLOW_LEN     = 28,
  parameter int REF_INTERVAL = 1280
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [BANK_W-1:0] bank,
  input  logic              rom_sel,
  input  logic              fio_sel,
  input  logic              fast_mode,
  output logic              ready,
  output logic              cyc_fast,
  output logic              refresh
);
  logic eff_mode, acc_fast, due, serve;

  speed_class #(.BANK_W(BANK_W)) u_class (
    .eff_mode (eff_mode),
    .bank     (bank),
    .rom_sel  (rom_sel),
    .fio_sel  (fio_sel),
    .acc_fast (acc_fast)
  );

  refresh_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .serve (serve),
    .due   (due)
  );

  cycle_seq #(.FAST_LEN(FAST_LEN), .SLOW_LEN(SLOW_LEN)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .rom_sel   (rom_sel),
    .fast_mode (fast_mode),
    .acc_fast  (acc_fast),
    .due       (due),
    .eff_mode  (eff_mode),
    .serve     (serve),
    .ready     (ready),
    .cyc_fast  (cyc_fast),
    .refresh   (refresh)
  );
endmodule

// File: tb/speed_cycle_ctrl_tb.sv
module speed_cycle_ctrl_tb;
  localparam int FL = 4;
  localparam int SL = 9;
  localparam int RI = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [7:0] bank = 8'h00;
  logic rom_sel = 1'b0;
  logic fio_sel = 1'b0;
  logic fast_mode = 1'b0;
  logic ready, cyc_fast, refresh;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  speed_cycle_ctrl #(.BANK_W(8), .FAST_LEN(FL), .SLOW_LEN(SL), .REF_INTERVAL(RI)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .bank(bank), .rom_sel(rom_sel),
    .fio_sel(fio_sel), .fast_mode(fast_mode), .ready(ready),
    .cyc_fast(cyc_fast), .refresh(refresh)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  // Idle until a strobe is seen; returns in the sampled phase of that cycle.
  task automatic wait_strobe();
    for (int i = 0; i < 4 * RI; i++) begin
      step();
      if (refresh) return;
    end
    chk(1'b0, "R6 strobe never seen", 0, 1);
  endtask

  // One access with handshake; measures the stall after acceptance.
  task automatic access(input logic [7:0] b, input logic r, input logic f,
                        input logic m, input bit flip, input string tag);
    bit exp_fast;
    int exp_len, lows;
    bit stolen;
    exp_fast = m && ((b < 8'h80) || r || f);
    exp_len  = exp_fast ? FL - 1 : SL - 1;
    bank = b; rom_sel = r; fio_sel = f; fast_mode = m; req = 1'b1;
    #1;
    for (int i = 0; i < 100 && !ready; i++) step();
    step();
    req = 1'b0;
    if (flip) fast_mode = !m;
    #1;
    chk(cyc_fast == exp_fast, {tag, " cyc_fast"}, cyc_fast, exp_fast);
    lows = 0; stolen = 0;
    while (!ready && lows < 200) begin
      lows++;
      step();
      if (lows == exp_len && refresh && !ready) stolen = 1;
    end
    chk(lows == exp_len + (stolen ? FL : 0), {tag, " stall"}, lows,
        exp_len + (stolen ? FL : 0));
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int strobes;
    bit ready_ok;
    int lows;

    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    chk(ready == 1'b1 && cyc_fast == 1'b0 && refresh == 1'b0, "R1 during reset",
        {ready, cyc_fast, refresh}, 3'b100);
    @(negedge clk); rst_n = 1'b1; #1;
    chk(ready == 1'b1 && cyc_fast == 1'b0 && refresh == 1'b0, "R1 after reset",
        {ready, cyc_fast, refresh}, 3'b100);

    // R10 slow idle: strobes once per interval, ready untouched
    fast_mode = 1'b0;
    wait_strobe();
    strobes = 0; ready_ok = 1;
    for (int i = 1; i <= 3 * RI; i++) begin
      step();
      if (refresh) strobes++;
      if (!ready) ready_ok = 0;
    end
    chk(strobes == 3, "R10 slow strobe count", strobes, 3);
    chk(ready_ok, "R10 slow ready held", ready_ok, 1);

    // R6 / R7 fast idle: periodic stolen slots of FL clocks
    fast_mode = 1'b1;
    wait_strobe();
    chk(ready == 1'b0, "R7 ready at strobe", ready, 0);
    for (int i = 1; i <= 2 * RI; i++) begin
      step();
      chk(refresh == ((i % RI) == 0), "R6 strobe timing", refresh, (i % RI) == 0);
      chk(ready == !((i % RI) < FL), "R7 stolen slot ready", ready, !((i % RI) < FL));
    end

    // R8 request held across a stolen slot
    wait_strobe();
    repeat (RI - 1) @(negedge clk);
    @(negedge clk);
    bank = 8'h12; rom_sel = 1'b0; fio_sel = 1'b0; req = 1'b1;
    #1;
    chk(refresh == 1'b1 && ready == 1'b0, "R8 strobe with held req",
        {refresh, ready}, 2'b10);
    lows = 0;
    while (!ready && lows < 50) begin lows++; step(); end
    chk(lows == FL, "R8 held wait", lows, FL);
    step(); req = 1'b0; #1;
    lows = 0;
    while (!ready && lows < 50) begin lows++; step(); end
    chk(lows == FL - 1, "R8 held access stall", lows, FL - 1);
    chk(cyc_fast == 1'b1, "R8 held access type", cyc_fast, 1);

    // R9 ROM beats a due refresh; refresh taken right after
    wait_strobe();
    repeat (RI - 1) @(negedge clk);
    @(negedge clk);
    bank = 8'hFE; rom_sel = 1'b1; fio_sel = 1'b0; req = 1'b1;
    #1;
    chk(ready == 1'b1 && refresh == 1'b0, "R9 ROM not delayed",
        {ready, refresh}, 2'b10);
    step(); req = 1'b0; rom_sel = 1'b0; #1;
    lows = 0;
    while (!ready && !refresh && lows < 50) begin lows++; step(); end
    chk(lows == FL - 1, "R9 ROM stall", lows, FL - 1);
    chk(refresh == 1'b1 && ready == 1'b0, "R9 deferred refresh",
        {refresh, ready}, 2'b10);
    lows = 0;
    while (!ready && lows < 50) begin lows++; step(); end
    chk(lows == FL, "R9 deferred slot length", lows, FL);

    // R2 R3 R4 R5 sweep over mode, bank and flags
    for (int m = 0; m < 2; m++)
      for (int fl = 0; fl < 4; fl++)
        for (int b = 0; b < 256; b++)
          access(8'(b), fl[0], fl[1], m[0], 1'b0, m ? "R3 R4 R2 fast mode" : "R5 R2 slow mode");

    // R11 mode flips during an access
    access(8'h05, 1'b0, 1'b0, 1'b1, 1'b1, "R11 fast then flip");
    access(8'h05, 1'b0, 1'b0, 1'b0, 1'b1, "R11 slow then flip");
    access(8'hE1, 1'b0, 1'b0, 1'b1, 1'b1, "R11 R4 shared bank flip");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule